// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block accepts hardware interrupts for a small 8-bit accumulator-style processor and runs the bus cycles that enter the handler. It watches a level-sensitive, active-low maskable request and an active-low non-maskable request that is latched on its falling edge. It only decides whether to take an interrupt at an instruction boundary. When a request is pending there, the block steals the next opcode fetch. It performs the read but throws the opcode away and puts a forced break code in its place. The program counter stays where it is. The block then writes the return address and status to the stack and loads the new program counter from the vector.

A minimal core is built around the sequencer so that the behaviour can be seen at the ports. Every ordinary opcode takes two cycles: a fetch and one execute cycle. Opcode 0x58 clears the interrupt-disable flag and opcode 0x78 sets it. Opcode 0x40 restores the status and the program counter from the stack. Every other opcode behaves as a no-operation. Because the address pushed on entry is the address of the stolen fetch, the same opcode is fetched again after the return. If the request is still active at that point, the opcode is pre-empted once more.

Top module: `irq_entry_seq`

## Requirements
- R1: Each normal instruction takes two cycles. The fetch cycle has sync=1, mem_we=0 and mem_addr=PC. The next cycle reads PC+1. The following fetch is at PC+1.
- R2: An interrupt is never entered partway through an instruction. A request that appears during an instruction's fetch lets that instruction finish, and the entry starts on the next fetch.
- R3: On a stolen fetch, sync=1 and a read of address A is performed, but the opcode is discarded and the PC is not advanced. The next cycle reads A again.
- R4: The entry then makes three writes in stack page 0x01. The first is the PC high byte at 0x01SP, the second is the PC low byte at 0x01(SP-1), and the third is the status byte at 0x01(SP-2). SP decrements after each write.
- R5: In the pushed status byte, bit 4 is 0, bit 5 is 1 and bit 2 holds the interrupt-disable flag. The flag is set once the push is done.
- R6: The vector is read low byte first: 0xFFFE/0xFFFF for the maskable request and 0xFFFA/0xFFFB for the non-maskable one. The first fetch at the vector comes exactly seven cycles after the stolen fetch.
- R7: A falling edge on nmi_n is latched and taken even while the disable flag is 1. Holding nmi_n low does not trigger a second entry.
- R8: If both requests are pending at the same boundary, the non-maskable vector is used.
- R9: After the instruction that clears the disable flag, one more instruction completes before a pending maskable request steals a fetch.
- R10: Opcode 0x40 reads status, then PC low, then PC high from 0x01(SP+1) upward and resumes at the restored address. If irq_n is still low, that same fetch is stolen again.
- R11: While the disable flag is 1, a low irq_n causes no entry.
- R12: After reset the first fetch is at 0x0200, SP is 0xFF and irq_disable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| nmi_n | input | 1 | Non-maskable request, taken on a falling edge |
| mem_addr | output | 16 | Bus address |
| mem_rdata | input | 8 | Read data for the current address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| sync | output | 1 | High in opcode fetch cycles |
| irq_disable | output | 1 | Interrupt-disable flag |

## Verification
The bench follows the bus cycle by cycle in several situations:
- A masked request held low shows that the disable flag alone blocks entry.
- A request that is already low when the flag is cleared shows the one-instruction delay and the unadvanced PC.
- A handler made only of a return, with the request still held, shows the same fetch being stolen again. Releasing the request then lets that opcode finally run.
- A falling edge with the flag set, and a falling edge that coincides with a maskable request, separate the edge latch from the level mask and check vector priority. They also show that holding nmi_n low does not retrigger.

// File: rtl/ies_pkg.sv
package ies_pkg;
  typedef enum logic [3:0] {
    ST_FETCH, ST_EXEC,
    ST_PUSH_H, ST_PUSH_L, ST_PUSH_P,
    ST_VEC_L, ST_VEC_H,
    ST_POP_P, ST_POP_L, ST_POP_H
  } ies_state_t;

  localparam logic [7:0] OP_BRK = 8'h00;
  localparam logic [7:0] OP_CLI = 8'h58;
  localparam logic [7:0] OP_SEI = 8'h78;
  localparam logic [7:0] OP_RTI = 8'h40;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;
endpackage

// File: rtl/ies_req_sampler.sv
module ies_req_sampler (
  input  logic clk,
  input  logic rst,
  input  logic irq_n,
  input  logic nmi_n,
  input  logic poll,
  input  logic i_flag,
  input  logic take_nmi,
  output logic irq_pend,
  output logic nmi_pend
);
  logic nmi_q;
  logic nmi_fall;

  assign nmi_fall = nmi_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_n;
      // a new edge wins over the clear of the one being taken
      nmi_pend <= nmi_fall | (nmi_pend & ~take_nmi);
      if (poll) irq_pend <= ~irq_n & ~i_flag;
    end
  end

  p_nmi_latch_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |=> nmi_pend);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    (poll && i_flag) |=> !irq_pend);
endmodule

// File: rtl/ies_ctrl.sv
module ies_ctrl
  import ies_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              irq_pend,
  input  logic              nmi_pend,
  output ies_state_t        state,
  output logic              hijack,
  output logic              take_nmi,
  output logic              vec_nmi,
  output logic              poll,
  output logic              op_cli,
  output logic              op_sei
);
  ies_state_t        state_nx;
  logic [DATA_W-1:0] ir;
  logic              hw_int;

  assign hijack   = (state == ST_FETCH) && (nmi_pend || irq_pend);
  assign take_nmi = hijack && nmi_pend;
  assign op_cli   = (state == ST_EXEC) && !hw_int && (ir == DATA_W'(OP_CLI));
  assign op_sei   = (state == ST_EXEC) && !hw_int && (ir == DATA_W'(OP_SEI));

  always_comb begin
    state_nx = state;
    poll     = 1'b0;
    case (state)
      ST_FETCH:  state_nx = ST_EXEC;
      ST_EXEC: begin
        if (hw_int && ir == DATA_W'(OP_BRK)) state_nx = ST_PUSH_H;
        else if (ir == DATA_W'(OP_RTI))      state_nx = ST_POP_P;
        else begin
          state_nx = ST_FETCH;
          poll     = 1'b1;
        end
      end
      ST_PUSH_H: state_nx = ST_PUSH_L;
      ST_PUSH_L: state_nx = ST_PUSH_P;
      ST_PUSH_P: state_nx = ST_VEC_L;
      ST_VEC_L:  state_nx = ST_VEC_H;
      ST_VEC_H: begin
        state_nx = ST_FETCH;
        poll     = 1'b1;
      end
      ST_POP_P:  state_nx = ST_POP_L;
      ST_POP_L:  state_nx = ST_POP_H;
      ST_POP_H: begin
        state_nx = ST_FETCH;
        poll     = 1'b1;
      end
      default:   state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      ir      <= '0;
      hw_int  <= 1'b0;
      vec_nmi <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_FETCH) begin
        // the fetched opcode is dropped and a break code stands in for it
        ir     <= hijack ? DATA_W'(OP_BRK) : mem_rdata;
        hw_int <= hijack;
        if (hijack) vec_nmi <= nmi_pend;
      end
    end
  end

  p_nmi_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (hijack && nmi_pend && irq_pend) |=> (state == ST_EXEC && vec_nmi));
endmodule

// File: rtl/ies_datapath.sv
module ies_datapath
  import ies_pkg::*;
#(
  parameter int                     ADDR_W     = 16,
  parameter int                     DATA_W     = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
  parameter logic [ADDR_W-1:0]      IRQ_VEC    = 'hFFFE,
  parameter logic [ADDR_W-1:0]      NMI_VEC    = 'hFFFA,
  parameter logic [ADDR_W-1:0]      RESET_PC   = 'h0200,
  parameter logic [DATA_W-1:0]      RESET_SP   = 'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  ies_state_t        state,
  input  logic              hijack,
  input  logic              vec_nmi,
  input  logic              op_cli,
  input  logic              op_sei,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              sync,
  output logic              i_flag
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [DATA_W-1:0] P_RESET = DATA_W'(1) << FLAG_I;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] sp;
  logic [DATA_W-1:0] p_q;
  logic [DATA_W-1:0] p_push;
  logic [DATA_W-1:0] p_pop;
  logic [DATA_W-1:0] sp_up;
  logic [ADDR_W-1:0] vec_base;

  assign i_flag   = p_q[FLAG_I];
  assign sp_up    = sp + 1'b1;
  assign vec_base = vec_nmi ? NMI_VEC : IRQ_VEC;

  always_comb begin
    p_push         = p_q;
    p_push[FLAG_U] = 1'b1;
    p_push[FLAG_B] = 1'b0;
    p_pop          = mem_rdata;
    p_pop[FLAG_U]  = 1'b0;
    p_pop[FLAG_B]  = 1'b0;
  end

  always_comb begin
    mem_addr  = pc;
    mem_wdata = '0;
    mem_we    = 1'b0;
    case (state)
      ST_PUSH_H: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = pc[ADDR_W-1:DATA_W];
        mem_we    = 1'b1;
      end
      ST_PUSH_L: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = pc[DATA_W-1:0];
        mem_we    = 1'b1;
      end
      ST_PUSH_P: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = p_push;
        mem_we    = 1'b1;
      end
      ST_VEC_L:  mem_addr = vec_base;
      ST_VEC_H:  mem_addr = vec_base | ADDR_W'(1);
      ST_POP_P, ST_POP_L, ST_POP_H: mem_addr = {STACK_PAGE, sp_up};
      default:   mem_addr = pc;
    endcase
  end

  assign sync = (state == ST_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= RESET_PC;
      sp  <= RESET_SP;
      p_q <= P_RESET;
    end else begin
      case (state)
        ST_FETCH:  if (!hijack) pc <= pc + 1'b1;
        ST_EXEC: begin
          if (op_cli) p_q[FLAG_I] <= 1'b0;
          if (op_sei) p_q[FLAG_I] <= 1'b1;
        end
        ST_PUSH_H, ST_PUSH_L: sp <= sp - 1'b1;
        ST_PUSH_P: begin
          sp          <= sp - 1'b1;
          p_q[FLAG_I] <= 1'b1;
        end
        ST_VEC_L:  pc[DATA_W-1:0] <= mem_rdata;
        ST_VEC_H:  pc[ADDR_W-1:DATA_W] <= mem_rdata[HI_W-1:0];
        ST_POP_P: begin
          sp  <= sp_up;
          p_q <= p_pop;
        end
        ST_POP_L: begin
          sp             <= sp_up;
          pc[DATA_W-1:0] <= mem_rdata;
        end
        ST_POP_H: begin
          sp                  <= sp_up;
          pc[ADDR_W-1:DATA_W] <= mem_rdata[HI_W-1:0];
        end
        default: ;
      endcase
    end
  end

  p_fetch_is_read_r1: assert property (@(posedge clk) disable iff (rst)
    sync |-> !mem_we);

  p_hijack_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    hijack |=> (mem_addr == $past(mem_addr)));

  p_push_sp_dec_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (sp == $past(sp) - 1'b1));

  p_mask_after_push_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PUSH_P) |=> i_flag);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_n,
  input  logic              nmi_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              sync,
  output logic              irq_disable
);
  ies_state_t state;
  logic hijack, take_nmi, vec_nmi, poll, op_cli, op_sei;
  logic irq_pend, nmi_pend, i_flag;

  assign irq_disable = i_flag;

  ies_req_sampler u_req (
    .clk(clk), .rst(rst), .irq_n(irq_n), .nmi_n(nmi_n),
    .poll(poll), .i_flag(i_flag), .take_nmi(take_nmi),
    .irq_pend(irq_pend), .nmi_pend(nmi_pend)
  );

  ies_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata),
    .irq_pend(irq_pend), .nmi_pend(nmi_pend),
    .state(state), .hijack(hijack), .take_nmi(take_nmi),
    .vec_nmi(vec_nmi), .poll(poll), .op_cli(op_cli), .op_sei(op_sei)
  );

  ies_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk(clk), .rst(rst), .state(state), .hijack(hijack),
    .vec_nmi(vec_nmi), .op_cli(op_cli), .op_sei(op_sei),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .sync(sync), .i_flag(i_flag)
  );
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_n = 1'b1;
  logic        nmi_n = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        sync;
  logic        irq_disable;

  logic [7:0] prog [0:255];
  logic [7:0] stk  [0:255];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_entry_seq uut (
    .clk(clk), .rst(rst), .irq_n(irq_n), .nmi_n(nmi_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .sync(sync), .irq_disable(irq_disable)
  );

  // program at 0x02xx, stack at 0x01xx, IRQ handler 0x0280, NMI handler 0x0290
  always_comb begin
    case (mem_addr)
      16'hFFFE: mem_rdata = 8'h80;
      16'hFFFF: mem_rdata = 8'h02;
      16'hFFFA: mem_rdata = 8'h90;
      16'hFFFB: mem_rdata = 8'h02;
      default: begin
        if (mem_addr[15:8] == 8'h02)      mem_rdata = prog[mem_addr[7:0]];
        else if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
        else                              mem_rdata = 8'hEA;
      end
    endcase
  end

  always @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  task automatic cyc(input string tag, input bit e_sync, input logic [15:0] e_addr,
                     input bit e_we, input logic [7:0] e_wd);
    checks++;
    if (sync !== e_sync || mem_addr !== e_addr || mem_we !== e_we ||
        (e_we && mem_wdata !== e_wd)) begin
      errors++;
      $display("FAIL %s: got sync=%0b addr=%h we=%0b wd=%h expected sync=%0b addr=%h we=%0b wd=%h",
               tag, sync, mem_addr, mem_we, mem_wdata, e_sync, e_addr, e_we, e_wd);
    end
    @(negedge clk); #1;
  endtask

  task automatic fch(input string tag, input logic [15:0] a); cyc(tag, 1'b1, a, 1'b0, 8'h00); endtask
  task automatic rdc(input string tag, input logic [15:0] a); cyc(tag, 1'b0, a, 1'b0, 8'h00); endtask
  task automatic wrc(input string tag, input logic [15:0] a, input logic [7:0] d); cyc(tag, 1'b0, a, 1'b1, d); endtask

  task automatic chk_i(input string tag, input bit e);
    checks++;
    if (irq_disable !== e) begin
      errors++;
      $display("FAIL %s: irq_disable got %0b expected %0b", tag, irq_disable, e);
    end
  endtask

  task automatic load_prog();
    for (int k = 0; k < 256; k++) prog[k] = 8'hEA;
    prog[8'h80] = 8'h40;
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_n = 1'b1; nmi_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; #1;
  endtask

  task automatic t_reset();
    load_prog();
    do_reset();
    chk_i("R12 disable after reset", 1'b1);
    fch("R12 first fetch", 16'h0200);
  endtask

  task automatic t_masked_run();
    load_prog();
    do_reset();
    irq_n = 1'b0;
    fch("R1 fetch 0200", 16'h0200);
    rdc("R1 exec 0200", 16'h0201);
    fch("R11 masked fetch 0201", 16'h0201);
    rdc("R1 exec 0201", 16'h0202);
    fch("R11 masked fetch 0202", 16'h0202);
    rdc("R1 exec 0202", 16'h0203);
    irq_n = 1'b1;
  endtask

  task automatic t_cli_entry_return();
    load_prog();
    prog[8'h00] = 8'h58;
    do_reset();
    irq_n = 1'b0;
    fch("R9 fetch clear-flag op", 16'h0200);
    rdc("R2 exec clear-flag op", 16'h0201);
    fch("R9 next fetch not stolen", 16'h0201);
    rdc("R2 instruction completes", 16'h0202);
    fch("R3 stolen fetch", 16'h0202);
    rdc("R3 pc held", 16'h0202);
    wrc("R4 push pc high", 16'h01FF, 8'h02);
    wrc("R4 push pc low", 16'h01FE, 8'h02);
    wrc("R5 push status", 16'h01FD, 8'h20);
    rdc("R6 irq vector low", 16'hFFFE);
    rdc("R6 irq vector high", 16'hFFFF);
    chk_i("R5 flag set after entry", 1'b1);
    fch("R6 fetch at vector", 16'h0280);
    rdc("R10 return exec", 16'h0281);
    rdc("R10 pop status", 16'h01FD);
    rdc("R10 pop pc low", 16'h01FE);
    rdc("R10 pop pc high", 16'h01FF);
    chk_i("R10 status restored", 1'b0);
    fch("R10 refetch stolen", 16'h0202);
    rdc("R10 pre-empted again", 16'h0202);
    wrc("R10 push pc high again", 16'h01FF, 8'h02);
    irq_n = 1'b1;
    wrc("R4 push pc low again", 16'h01FE, 8'h02);
    wrc("R5 push status again", 16'h01FD, 8'h20);
    rdc("R6 vector low again", 16'hFFFE);
    rdc("R6 vector high again", 16'hFFFF);
    fch("R6 vector fetch again", 16'h0280);
    rdc("R10 return exec again", 16'h0281);
    rdc("R10 pop status again", 16'h01FD);
    rdc("R10 pop low again", 16'h01FE);
    rdc("R10 pop high again", 16'h01FF);
    fch("R10 refetch after release", 16'h0202);
    rdc("R10 instruction now runs", 16'h0203);
    fch("R1 following fetch", 16'h0203);
  endtask

  task automatic t_nmi_masked();
    load_prog();
    do_reset();
    fch("R7 fetch 0200", 16'h0200);
    nmi_n = 1'b0;
    rdc("R7 exec 0200", 16'h0201);
    fch("R7 stolen fetch with flag set", 16'h0201);
    rdc("R3 pc held nmi", 16'h0201);
    wrc("R4 nmi push high", 16'h01FF, 8'h02);
    wrc("R4 nmi push low", 16'h01FE, 8'h01);
    wrc("R5 nmi push status", 16'h01FD, 8'h24);
    rdc("R6 nmi vector low", 16'hFFFA);
    rdc("R6 nmi vector high", 16'hFFFB);
    fch("R6 nmi handler fetch", 16'h0290);
    rdc("R7 handler exec", 16'h0291);
    fch("R7 held low no retrigger", 16'h0291);
    rdc("R7 handler exec 2", 16'h0292);
    fch("R7 still no retrigger", 16'h0292);
    nmi_n = 1'b1;
  endtask

  task automatic t_nmi_priority();
    load_prog();
    prog[8'h00] = 8'h58;
    do_reset();
    irq_n = 1'b0;
    fch("R8 fetch 0200", 16'h0200);
    rdc("R8 exec clear-flag", 16'h0201);
    nmi_n = 1'b0;
    fch("R8 fetch 0201", 16'h0201);
    rdc("R8 exec 0201", 16'h0202);
    fch("R8 stolen fetch both pending", 16'h0202);
    rdc("R8 pc held", 16'h0202);
    wrc("R8 push high", 16'h01FF, 8'h02);
    wrc("R8 push low", 16'h01FE, 8'h02);
    wrc("R8 push status", 16'h01FD, 8'h20);
    rdc("R8 nmi vector low wins", 16'hFFFA);
    rdc("R8 nmi vector high wins", 16'hFFFB);
    fch("R8 nmi handler", 16'h0290);
    rdc("R11 handler exec", 16'h0291);
    fch("R11 irq blocked in handler", 16'h0291);
    irq_n = 1'b1;
    nmi_n = 1'b1;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_masked_run();
    t_cli_entry_return();
    t_nmi_masked();
    t_nmi_priority();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule